// File: doc/BRIEF.md
# PWM Global Enable and Interrupt Register Bank

This block is the shared control register file of a multi-channel pulse-width modulator. Software starts and stops channels through two separate registers. One sets the selected run bits and the other clears them, and a third address reads the run bits back. The per-channel interrupt mask is handled in the same way, with its own set, clear and readback addresses. Each channel's waveform generator sends a one-cycle pulse when it finishes a period. The block latches these pulses into an event status word, which clears when it is read. The block drives one interrupt line that is high while any latched event has its mask bit set.

The block also decodes the per-channel register windows. A window starts at byte address 0x200 and each channel's window is 0x20 bytes wide. On an access in a window, the block raises that channel's select line and passes the low five address bits on. Read data from the selected channel is returned on the shared read bus. The waveform logic itself sits outside the block: the block sees it only through the run outputs, the period-event inputs and the window selects. Reads are combinational, so read data is valid in the same cycle as the read strobe. Writes and the clear caused by a read take effect at the next rising clock edge.

Top module: `pwmc_global_ctl`

## Requirements
- R1: After a synchronous active-low reset, the run bits, the mask bits, the event status and the mode word are all zero, and `irq` is low.
- R2: A write to byte address 0x04 sets run bit n for every 1 in bit n of the write data. Run bits whose data bit is 0 keep their value. The run bits read back at address 0x0C in bits [NCH-1:0].
- R3: A write to address 0x08 clears run bit n for every 1 in bit n of the write data. A 0 bit leaves that run bit unchanged.
- R4: A write to 0x10 sets interrupt mask bit n for every 1 in the data, and a write to 0x14 clears it for every 1 in the data. The mask reads back at 0x18.
- R5: A high pulse on `period_evt[n]` sets event status bit n, and the bit holds until the status is read at 0x1C. The read returns the status and clears it at the next edge.
- R6: An event that arrives in the same cycle as a read of 0x1C does not appear in that read's data. It stays set and is returned by the next read of 0x1C.
- R7: `irq` is high exactly when some event status bit and the matching mask bit are both 1.
- R8: Address 0x00 holds a 32-bit mode word. It can be read and written, and it drives `mode_cfg`.
- R9: Data bits at NCH and above read as zero and have no effect when written. Writes to 0x0C, 0x18 and 0x1C change nothing. A read of an unmapped address returns zero.
- R10: Any read or write at 0x200 + n*0x20 + k, for n < NCH, raises only `bank_sel[n]` in that cycle and drives `bank_ofs` = k. A read there returns that channel's slice of `bank_rdata`. For n >= NCH, no select is raised and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| mode_cfg | output | 32 | Mode word |
| chan_run | output | NCH | Run bit for each channel |
| period_evt | input | NCH | End-of-period pulse from each channel |
| irq | output | 1 | Interrupt request |
| bank_sel | output | NCH | One-hot channel window select |
| bank_ofs | output | 5 | Byte offset within the channel window |
| bank_rdata | input | NCH*32 | Read data from each channel window, channel 0 in the low word |

## Verification
The bench checks that a 0 bit written to the set or clear addresses leaves other channels alone. A design that loaded the register directly would silently stop or start unrelated channels. It also drives a period event into the same cycle as a status read. A design that cleared the status after the merge would lose that event, so the following read would come back zero. The mask is moved both before and after events are latched, to catch an interrupt that ignores the mask or misses a late enable. Accesses to channel windows past the last channel and to unmapped offsets are checked for no select and zero read data, which exposes a decoder that wraps the channel index.

// File: rtl/pwmc_pkg.sv
// Package: shared constants and types for the PWM global register bank.
// Assumes a 12-bit byte address and 32-bit word-aligned accesses.
package pwmc_pkg;
    localparam int DW      = 32;
    localparam int AW      = 12;
    localparam int OFS_W   = 5;
    localparam int IDX_W   = 4;

    localparam logic [AW-1:0] A_MODE   = 12'h000;
    localparam logic [AW-1:0] A_RUNSET = 12'h004;
    localparam logic [AW-1:0] A_RUNCLR = 12'h008;
    localparam logic [AW-1:0] A_RUNRD  = 12'h00C;
    localparam logic [AW-1:0] A_IMSET  = 12'h010;
    localparam logic [AW-1:0] A_IMCLR  = 12'h014;
    localparam logic [AW-1:0] A_IMRD   = 12'h018;
    localparam logic [AW-1:0] A_EVRD   = 12'h01C;
    localparam logic [2:0]    BANK_TAG = 3'b001;

    typedef struct packed {
        logic mode_wr;
        logic run_set;
        logic run_clr;
        logic im_set;
        logic im_clr;
        logic ev_rd;
    } ctl_strb_t;

    typedef enum logic [2:0] {
        RS_NONE, RS_MODE, RS_RUN, RS_MASK, RS_STAT, RS_BANK
    } rsel_t;
endpackage

// File: rtl/pwmc_addr_dec.sv
// Module: address decoder for the global registers and the channel windows.
// Assumes at most one of bus_wr / bus_rd per cycle and NCH <= 16.
module pwmc_addr_dec
    import pwmc_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [AW-1:0]        bus_addr,
    output ctl_strb_t            strb,
    output rsel_t                rsel,
    output logic [NCH-1:0]       bank_sel,
    output logic [OFS_W-1:0]     bank_ofs
);
    logic             in_bank;
    logic [IDX_W-1:0] bank_idx;

    assign in_bank  = (bus_addr[AW-1:9] == BANK_TAG);
    assign bank_idx = bus_addr[8:5];
    assign bank_ofs = bus_addr[OFS_W-1:0];

    // one select per implemented channel window
    for (genvar n = 0; n < NCH; n++) begin : g_sel
        assign bank_sel[n] = (bus_wr | bus_rd) & in_bank & (bank_idx == IDX_W'(n));
    end

    // write strobes for the global registers
    always_comb begin
        strb         = '0;
        strb.mode_wr = bus_wr & (bus_addr == A_MODE);
        strb.run_set = bus_wr & (bus_addr == A_RUNSET);
        strb.run_clr = bus_wr & (bus_addr == A_RUNCLR);
        strb.im_set  = bus_wr & (bus_addr == A_IMSET);
        strb.im_clr  = bus_wr & (bus_addr == A_IMCLR);
        strb.ev_rd   = bus_rd & (bus_addr == A_EVRD);
    end

    // read source selection
    always_comb begin
        rsel = RS_NONE;
        if (bus_rd) begin
            if (bus_addr == A_MODE)       rsel = RS_MODE;
            else if (bus_addr == A_RUNRD) rsel = RS_RUN;
            else if (bus_addr == A_IMRD)  rsel = RS_MASK;
            else if (bus_addr == A_EVRD)  rsel = RS_STAT;
            else if (|bank_sel)           rsel = RS_BANK;
        end
    end
endmodule

// File: rtl/pwmc_setclr_reg.sv
// Module: bit vector changed only by write-one-to-set and write-one-to-clear.
// Assumes set and clear strobes are never high together (separate addresses).
module pwmc_setclr_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] q
);
    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;

    assign set_m = set_stb ? wbits : '0;
    assign clr_m = clr_stb ? wbits : '0;

    // apply set then clear masks each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q | set_m) & ~clr_m;
    end

    // R2 R4
    set_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((q & $past(wbits)) == $past(wbits)));
    // R3 R4
    clr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((q & $past(wbits)) == '0));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(q));
endmodule

// File: rtl/pwmc_evt_latch.sv
// Module: sticky end-of-period status that clears when read.
// Assumes evt bits are single-cycle pulses; an event in the read cycle survives.
module pwmc_evt_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         rd_ack,
    output logic [W-1:0] status
);
    // accumulate events; a read restarts from the current cycle's events
    always_ff @(posedge clk) begin
        if (!rst_n)      status <= '0;
        else if (rd_ack) status <= evt;
        else             status <= status | evt;
    end

    // R5 R6
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> (status == $past(evt)));
    // R5
    event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ack |=> ((status & $past(status | evt)) == $past(status | evt)));
endmodule

// File: rtl/pwmc_global_ctl.sv
// Module: top of the PWM global register bank (run, interrupt mask,
// event status, mode word, channel window decode and read mux).
// Assumes single-cycle accesses with combinational read data.
module pwmc_global_ctl
    import pwmc_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [31:0]          mode_cfg,
    output logic [NCH-1:0]       chan_run,
    input  logic [NCH-1:0]       period_evt,
    output logic                 irq,
    output logic [NCH-1:0]       bank_sel,
    output logic [4:0]           bank_ofs,
    input  logic [NCH*32-1:0]    bank_rdata
);
    ctl_strb_t      strb;
    rsel_t          rsel;
    logic [NCH-1:0] im_q;
    logic [NCH-1:0] ev_q;
    logic [DW-1:0]  bank_mux;

    pwmc_addr_dec #(.NCH(NCH)) u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .strb     (strb),
        .rsel     (rsel),
        .bank_sel (bank_sel),
        .bank_ofs (bank_ofs)
    );

    pwmc_setclr_reg #(.W(NCH)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (strb.run_set),
        .clr_stb (strb.run_clr),
        .wbits   (bus_wdata[NCH-1:0]),
        .q       (chan_run)
    );

    pwmc_setclr_reg #(.W(NCH)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (strb.im_set),
        .clr_stb (strb.im_clr),
        .wbits   (bus_wdata[NCH-1:0]),
        .q       (im_q)
    );

    pwmc_evt_latch #(.W(NCH)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (period_evt),
        .rd_ack (strb.ev_rd),
        .status (ev_q)
    );

    // mode word register
    always_ff @(posedge clk) begin
        if (!rst_n)            mode_cfg <= '0;
        else if (strb.mode_wr) mode_cfg <= bus_wdata;
    end

    // interrupt request from unmasked latched events
    assign irq = |(ev_q & im_q);

    // AND-OR mux of the selected channel window's read data
    always_comb begin
        bank_mux = '0;
        for (int n = 0; n < NCH; n++) begin
            if (bank_sel[n]) bank_mux = bank_mux | bank_rdata[n*DW +: DW];
        end
    end

    // read data select
    always_comb begin
        unique case (rsel)
            RS_MODE: bus_rdata = mode_cfg;
            RS_RUN:  bus_rdata = DW'(chan_run);
            RS_MASK: bus_rdata = DW'(im_q);
            RS_STAT: bus_rdata = DW'(ev_q);
            RS_BANK: bus_rdata = bank_mux;
            default: bus_rdata = '0;
        endcase
    end

    // R8
    mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb.mode_wr |=> (mode_cfg == $past(bus_wdata)));
    // R10
    bank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel));
    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(period_evt) != '0 || $past(strb.im_set)));
endmodule

// File: tb/sim_pwmc_global_ctl.sv
// Bench: vector table walk followed by directed interrupt, race, window and reset tests.
module sim_pwmc_global_ctl;
    localparam int NCH = 4;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 12'h00C, 32'h0, 32'h0, 4'd1},          // R1 run
        '{OP_RD, 12'h018, 32'h0, 32'h0, 4'd1},          // R1 mask
        '{OP_RD, 12'h01C, 32'h0, 32'h0, 4'd1},          // R1 status
        '{OP_RD, 12'h000, 32'h0, 32'h0, 4'd1},          // R1 mode
        '{OP_WR, 12'h004, 32'h5, 32'h0, 4'd2},
        '{OP_RD, 12'h00C, 32'h0, 32'h5, 4'd2},          // R2
        '{OP_WR, 12'h004, 32'h2, 32'h0, 4'd2},
        '{OP_RD, 12'h00C, 32'h0, 32'h7, 4'd2},          // R2 zeros keep
        '{OP_WR, 12'h008, 32'h4, 32'h0, 4'd3},
        '{OP_RD, 12'h00C, 32'h0, 32'h3, 4'd3},          // R3
        '{OP_WR, 12'h008, 32'h0, 32'h0, 4'd3},
        '{OP_RD, 12'h00C, 32'h0, 32'h3, 4'd3},          // R3 zeros keep
        '{OP_WR, 12'h004, 32'hFFFF_FFF0, 32'h0, 4'd9},
        '{OP_RD, 12'h00C, 32'h0, 32'h3, 4'd9},          // R9 upper bits
        '{OP_WR, 12'h00C, 32'hF, 32'h0, 4'd9},
        '{OP_RD, 12'h00C, 32'h0, 32'h3, 4'd9},          // R9 readback write
        '{OP_WR, 12'h010, 32'h9, 32'h0, 4'd4},
        '{OP_RD, 12'h018, 32'h0, 32'h9, 4'd4},          // R4 set
        '{OP_WR, 12'h014, 32'h1, 32'h0, 4'd4},
        '{OP_RD, 12'h018, 32'h0, 32'h8, 4'd4},          // R4 clear
        '{OP_WR, 12'h018, 32'hF, 32'h0, 4'd9},
        '{OP_RD, 12'h018, 32'h0, 32'h8, 4'd9},          // R9 mask readback write
        '{OP_WR, 12'h000, 32'hA5A5_1234, 32'h0, 4'd8},
        '{OP_RD, 12'h000, 32'h0, 32'hA5A5_1234, 4'd8},  // R8
        '{OP_EV, 12'h000, 32'h3, 32'h0, 4'd5},
        '{OP_RD, 12'h01C, 32'h0, 32'h3, 4'd5},          // R5 latched
        '{OP_RD, 12'h01C, 32'h0, 32'h0, 4'd5},          // R5 cleared
        '{OP_EV, 12'h000, 32'h4, 32'h0, 4'd5},
        '{OP_WR, 12'h01C, 32'hF, 32'h0, 4'd9},
        '{OP_RD, 12'h01C, 32'h0, 32'h4, 4'd9},          // R9 write does not clear
        '{OP_RD, 12'h040, 32'h0, 32'h0, 4'd9},          // R9 unmapped
        '{OP_RD, 12'h0C4, 32'h0, 32'h0, 4'd9}           // R9 unmapped
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [31:0]        mode_cfg;
    logic [NCH-1:0]     chan_run;
    logic [NCH-1:0]     period_evt = '0;
    logic               irq;
    logic [NCH-1:0]     bank_sel;
    logic [4:0]         bank_ofs;
    logic [NCH*32-1:0]  bank_rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    // each channel window returns a tag of its index and the offset
    for (genvar n = 0; n < NCH; n++) begin : g_bank
        assign bank_rdata[n*32 +: 32] = {16'hBA00 | 16'(n), 11'b0, bank_ofs};
    end

    pwmc_global_ctl #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mode_cfg(mode_cfg), .chan_run(chan_run), .period_evt(period_evt),
        .irq(irq), .bank_sel(bank_sel), .bank_ofs(bank_ofs),
        .bank_rdata(bank_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2 check(tag, bus_rdata, exp);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [NCH-1:0] e);
        @(negedge clk);
        period_evt = e;
        @(posedge clk); #1;
        period_evt = '0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        #2 check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_irq(1'b0, "R1 irq after reset");

        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("R%0d vector %0d", VEC[i].req, i);
            case (VEC[i].op)
                OP_WR:   wr(VEC[i].addr, VEC[i].data);
                OP_RD:   rd(VEC[i].addr, VEC[i].exp, t);
                default: pulse(VEC[i].data[NCH-1:0]);
            endcase
        end

        // R7: mask is 8, status is 0 here
        pulse(4'h1);
        chk_irq(1'b0, "R7 masked event");
        pulse(4'h8);
        chk_irq(1'b1, "R7 unmasked event");
        wr(12'h014, 32'h8);
        chk_irq(1'b0, "R7 mask cleared");
        wr(12'h010, 32'h1);
        chk_irq(1'b1, "R7 late mask set");
        rd(12'h01C, 32'h9, "R5 status before irq clear");
        chk_irq(1'b0, "R7 cleared by read");

        // R6: event during the status read
        pulse(4'h1);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 12'h01C; period_evt = 4'h2;
        #2 check("R6 read during event", bus_rdata, 32'h1);
        @(posedge clk); #1;
        bus_rd = 1'b0; period_evt = '0;
        rd(12'h01C, 32'h2, "R6 event kept");
        rd(12'h01C, 32'h0, "R6 then empty");

        // R10: channel windows
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 12'h24C;
        #2;
        check("R10 sel ch2", 32'(bank_sel), 32'h4);
        check("R10 offset", 32'(bank_ofs), 32'hC);
        check("R10 rdata ch2", bus_rdata, {16'hBA02, 11'b0, 5'h0C});
        @(posedge clk); #1 bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h260; bus_wdata = 32'h1;
        #2 check("R10 sel ch3 write", 32'(bank_sel), 32'h8);
        @(posedge clk); #1 bus_wr = 1'b0;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 12'h280;
        #2;
        check("R10 no sel past last", 32'(bank_sel), 32'h0);
        check("R10 rdata past last", bus_rdata, 32'h0);
        @(posedge clk); #1 bus_rd = 1'b0;
        @(negedge clk);
        bus_addr = 12'h200;
        #2 check("R10 no sel when idle", 32'(bank_sel), 32'h0);
        check("R9 run kept after window write", 32'(chan_run), 32'h3);

        // R1: reset in the middle of activity
        wr(12'h010, 32'hF);
        pulse(4'hF);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        chk_irq(1'b0, "R1 irq after re-reset");
        rd(12'h00C, 32'h0, "R1 run after re-reset");
        rd(12'h018, 32'h0, "R1 mask after re-reset");
        rd(12'h01C, 32'h0, "R1 status after re-reset");
        rd(12'h000, 32'h0, "R1 mode after re-reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule